// File: doc/BRIEF.md
# Credit-Controlled Latency Link

This block joins a producing side and a consuming side that sit several clock cycles apart. A word goes forward on a data path of `LAT` cycles. A credit token comes back on a separate return path of `LAT` cycles. The two ends share no FIFO control.

The transmit end keeps a credit count and takes a word from local logic only while that count is nonzero. The receive end parks arriving words in a buffer of `2*LAT` entries. It hands them to local logic through a valid/ready port. Every word consumed there starts one credit on its way back.

The buffer depth equals the round-trip time, so a steady stream keeps flowing at one word per cycle while credits are still in transit.

Top module: `credit_link`

## Requirements
- R1: After reset the buffer is empty (`dst_valid` low) and the credit count is full, so `src_ready` is high.
- R2: `src_ready` is high exactly when at least one credit remains. A word is taken only in a cycle where `src_valid` and `src_ready` are both high.
- R3: The credit count starts at `2*LAT`. With the consumer stalled, exactly `2*LAT` words are accepted, and after that `src_ready` stays low.
- R4: A word accepted while the link is idle appears on `dst_valid`/`dst_data` exactly `LAT` cycles after the cycle in which it was accepted.
- R5: With no credits left, a word consumed at the output in cycle c raises `src_ready` in cycle c+`LAT`.
- R6: In a cycle that both sends a word and receives a returned credit, the credit count is unchanged. With `src_valid` and `dst_ready` held high, `src_ready` never drops and one word per cycle passes.
- R7: Words leave in the order they were accepted, with none lost and none duplicated.
- R8: While `dst_valid` is high and `dst_ready` is low, `dst_valid` stays high and `dst_data` holds its value.
- R9: The receive buffer never holds more than `2*LAT` words, and no word arrives while the buffer is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_valid | input | 1 | Producer offers a word |
| src_data | input | DATA_W | Offered word |
| src_ready | output | 1 | A credit is available; the word is taken this cycle |
| dst_valid | output | 1 | Head word of the receive buffer is present |
| dst_data | output | DATA_W | Head word of the receive buffer |
| dst_ready | input | 1 | Consumer takes the head word this cycle |

## Verification
A send at the transmit end and the arrival of a returned credit can fall in the same cycle. When they do, the count must neither drop nor rise. A steady stream with both handshakes held high provokes this on every cycle once the first credit has made its round trip. The stream test judges it from the ports: `src_ready` must never fall, and the number of words accepted and delivered over a fixed window must match the one-per-cycle rate less the forward latency. A bound checker also watches the count across such cycles.

// File: rtl/credit_link_pkg.sv
`timescale 1ns/1ps
package credit_link_pkg;
  // receive buffer must cover a full round trip
  function automatic int buf_depth(input int lat);
    return 2 * lat;
  endfunction

  function automatic int count_width(input int n);
    return $clog2(n + 1);
  endfunction

  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cl_pipe.sv
`timescale 1ns/1ps
// Fixed-latency wire model: STAGES register stages, zero stages is a pass-through.
module cl_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  generate
    if (STAGES == 0) begin : g_wire
      assign d_out = d_in;
    end else begin : g_regs
      logic [W-1:0] stage_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_in;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign d_out = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cl_sender.sv
`timescale 1ns/1ps
module cl_sender #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  input  logic              credit_in,
  output logic              tx_vld,
  output logic [DATA_W-1:0] tx_dat,
  output logic [CW-1:0]     credits
);
  logic [CW-1:0] credit_q;
  logic          fire;

  assign src_ready = (credit_q != '0);
  assign fire      = src_valid && src_ready;
  assign tx_vld    = fire;
  assign tx_dat    = src_data;
  assign credits   = credit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= CW'(DEPTH);
    end else begin
      case ({fire, credit_in})
        2'b10:   credit_q <= credit_q - 1'b1;
        2'b01:   credit_q <= credit_q + 1'b1;
        default: credit_q <= credit_q;
      endcase
    end
  end
endmodule

// File: rtl/cl_receiver.sv
`timescale 1ns/1ps
module cl_receiver #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 6,
  parameter int CW     = 3,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_vld,
  input  logic [DATA_W-1:0] rx_dat,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  input  logic              dst_ready,
  output logic              credit_out,
  output logic [CW-1:0]     fill
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     fill_q;
  logic              pop;

  assign dst_valid  = (fill_q != '0);
  assign dst_data   = mem[rd_ptr];
  assign pop        = dst_valid && dst_ready;
  assign credit_out = pop;
  assign fill       = fill_q;

  // storage without reset so a RAM can be inferred
  always_ff @(posedge clk) begin
    if (rx_vld) mem[wr_ptr] <= rx_dat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill_q <= '0;
    end else begin
      if (rx_vld) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)    rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({rx_vld, pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/credit_link.sv
`timescale 1ns/1ps
module credit_link
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              dst_valid,
  output logic [DATA_W-1:0] dst_data,
  input  logic              dst_ready
);
  localparam int DEPTH = buf_depth(LAT);
  localparam int CW    = count_width(DEPTH);
  localparam int AW    = addr_width(DEPTH);
  // the far-end register (buffer write / credit counter) is the last cycle of each hop
  localparam int STG   = LAT - 1;

  logic              tx_vld;
  logic [DATA_W-1:0] tx_dat;
  logic              arr_vld;
  logic [DATA_W-1:0] arr_dat;
  logic              cred_send;
  logic [0:0]        cred_arr;
  logic [CW-1:0]     credit_cnt;
  logic [CW-1:0]     fill_cnt;

  cl_sender #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_tx (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .credit_in(cred_arr[0]),
    .tx_vld(tx_vld), .tx_dat(tx_dat), .credits(credit_cnt)
  );

  cl_pipe #(.W(DATA_W+1), .STAGES(STG)) u_fwd (
    .clk(clk), .rst(rst),
    .d_in({tx_vld, tx_dat}), .d_out({arr_vld, arr_dat})
  );

  cl_receiver #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW), .AW(AW)) u_rx (
    .clk(clk), .rst(rst),
    .rx_vld(arr_vld), .rx_dat(arr_dat),
    .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready),
    .credit_out(cred_send), .fill(fill_cnt)
  );

  cl_pipe #(.W(1), .STAGES(STG)) u_back (
    .clk(clk), .rst(rst),
    .d_in(cred_send), .d_out(cred_arr)
  );
endmodule

// File: rtl/credit_link_chk.sv
`timescale 1ns/1ps
module credit_link_chk
  import credit_link_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LAT    = 3
) (
  input logic                                   clk,
  input logic                                   rst,
  input logic                                   src_valid,
  input logic                                   src_ready,
  input logic                                   dst_valid,
  input logic                                   dst_ready,
  input logic [DATA_W-1:0]                      dst_data,
  input logic [count_width(buf_depth(LAT))-1:0] credits,
  input logic [count_width(buf_depth(LAT))-1:0] fill,
  input logic                                   arrive,
  input logic                                   credit_back
);
  localparam int DEPTH = buf_depth(LAT);
  localparam int CW    = count_width(DEPTH);

  int  outstanding;
  logic sent, took;
  assign sent = src_valid && src_ready;
  assign took = dst_valid && dst_ready;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 0;
    else outstanding <= outstanding + (sent ? 1 : 0) - (took ? 1 : 0);
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (credits == CW'(DEPTH) && !dst_valid));

  a_r2_no_credit_no_ready: assert property (@(posedge clk) disable iff (rst)
    (credits == '0) |-> !src_ready);

  a_r3_credit_ceiling: assert property (@(posedge clk) disable iff (rst)
    credits <= CW'(DEPTH));

  a_r5_return_adds: assert property (@(posedge clk) disable iff (rst)
    (credit_back && !sent) |=> (credits == $past(credits) + 1'b1));

  a_r6_both_hold: assert property (@(posedge clk) disable iff (rst)
    (credit_back && sent) |=> $stable(credits));

  a_r7_conserve: assert property (@(posedge clk) disable iff (rst)
    (int'(credits) + outstanding) <= DEPTH);

  a_r8_hold_head: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    arrive |-> (fill < CW'(DEPTH)));
endmodule

bind credit_link credit_link_chk #(.DATA_W(DATA_W), .LAT(LAT)) u_chk (
  .clk(clk), .rst(rst),
  .src_valid(src_valid), .src_ready(src_ready),
  .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data),
  .credits(credit_cnt), .fill(fill_cnt),
  .arrive(arr_vld), .credit_back(cred_arr[0])
);

// File: tb/credit_link_test.sv
`timescale 1ns/1ps
module credit_link_test;
  localparam int DW    = 16;
  localparam int LAT   = 3;
  localparam int DEPTH = 2 * LAT;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          src_valid = 1'b0;
  logic [DW-1:0] src_data;
  logic          src_ready;
  logic          dst_valid;
  logic [DW-1:0] dst_data;
  logic          dst_ready = 1'b0;

  logic [DW-1:0] next_val = 16'h3A50;
  logic [DW-1:0] exp_q[$];
  int n_chk = 0, n_fail = 0, acc_cnt = 0, pop_cnt = 0;

  assign src_data = next_val;
  always #4 clk = ~clk;

  credit_link #(.DATA_W(DW), .LAT(LAT)) uut (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .dst_valid(dst_valid), .dst_data(dst_data), .dst_ready(dst_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard: R7 order, no loss, no duplication
  always @(posedge clk) begin
    if (!rst) begin
      if (src_valid && src_ready) begin
        exp_q.push_back(next_val);
        next_val <= next_val + 16'h0101;
        acc_cnt++;
      end
      if (dst_valid && dst_ready) begin
        pop_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R7 duplicate", int'(dst_data), -1);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(e == dst_data, "R7 order", int'(dst_data), int'(e));
        end
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    src_valid = 1'b0;
    dst_ready = 1'b1;
    for (int i = 0; i < 8 * DEPTH && (exp_q.size() != 0 || dst_valid); i++) @(negedge clk);
    repeat (2 * LAT + 2) @(negedge clk);
    dst_ready = 1'b0;
    chk(exp_q.size() == 0 && !dst_valid, "R7 drained", exp_q.size(), 0);
    chk(src_ready, "R2 credits restored", src_ready, 1);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(src_ready == 1'b1, "R1 src_ready after reset", src_ready, 1);
    chk(dst_valid == 1'b0, "R1 dst_valid after reset", dst_valid, 0);
  endtask

  task automatic t_stall();
    int a0, k;
    logic [DW-1:0] head;
    bit held;
    a0 = acc_cnt;
    dst_ready = 1'b0;
    src_valid = 1'b1;
    repeat (DEPTH + 4 * LAT) @(negedge clk);
    src_valid = 1'b0;
    chk(acc_cnt - a0 == DEPTH, "R3 words accepted under stall", acc_cnt - a0, DEPTH);
    chk(!src_ready, "R2 ready low at zero credits", src_ready, 0);
    head = dst_data;
    held = dst_valid;
    repeat (5) begin
      @(negedge clk);
      if (!dst_valid || dst_data != head) held = 1'b0;
    end
    chk(held, "R8 head held while stalled", int'(dst_data), int'(head));
    // one pop, then time the credit's return
    dst_ready = 1'b1;
    @(negedge clk);
    dst_ready = 1'b0;
    k = 1;
    while (!src_ready && k < 4 * LAT) begin
      @(negedge clk);
      k++;
    end
    chk(k == LAT, "R5 credit return delay", k, LAT);
    // exactly one more word fits
    a0 = acc_cnt;
    src_valid = 1'b1;
    repeat (3) @(negedge clk);
    src_valid = 1'b0;
    chk(acc_cnt - a0 == 1, "R2 single credit single word", acc_cnt - a0, 1);
    drain();
  endtask

  task automatic t_latency();
    int k;
    dst_ready = 1'b0;
    src_valid = 1'b1;
    @(negedge clk);
    src_valid = 1'b0;
    k = 1;
    while (!dst_valid && k < 4 * LAT) begin
      @(negedge clk);
      k++;
    end
    chk(k == LAT, "R4 forward latency", k, LAT);
    chk(exp_q.size() == 1 && dst_data == exp_q[0], "R4 delivered word", int'(dst_data),
        exp_q.size() ? int'(exp_q[0]) : -1);
    drain();
  endtask

  task automatic t_stream();
    int n, a0, p0, stalls;
    n = 10 * DEPTH;
    a0 = acc_cnt;
    p0 = pop_cnt;
    stalls = 0;
    src_valid = 1'b1;
    dst_ready = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!src_ready) stalls++;
    end
    src_valid = 1'b0;
    chk(stalls == 0, "R6 no stall in stream", stalls, 0);
    chk(acc_cnt - a0 == n, "R6 one word per cycle in", acc_cnt - a0, n);
    chk(pop_cnt - p0 == n - LAT, "R6 one word per cycle out", pop_cnt - p0, n - LAT);
    drain();
  endtask

  task automatic t_random();
    logic [15:0] lfsr;
    int worst;
    lfsr = 16'hACE1;
    worst = 0;
    for (int i = 0; i < 600; i++) begin
      src_valid = lfsr[0] | lfsr[7];
      dst_ready = lfsr[3] & ~(lfsr[9] & lfsr[11]);
      @(negedge clk);
      if (acc_cnt - pop_cnt > worst) worst = acc_cnt - pop_cnt;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    chk(worst <= DEPTH, "R9 held words within buffer depth", worst, DEPTH);
    drain();
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    t_reset();
    t_stall();
    t_latency();
    t_stream();
    t_random();
    chk(acc_cnt == pop_cnt, "R7 totals in equals out", pop_cnt, acc_cnt);
    finish_run();
  end
endmodule